// File: doc/BRIEF.md
# I2C SCL Divisor Calculation Unit

This unit turns a clock-rate request into the two divisor values that an I2C master's clock generator loads for the low and high phases of SCL. Software or a sequencer supplies the functional clock rate in Hz, the requested SCL rate in Hz, and the shortest allowed low and high phase times in nanoseconds. The caller pulses `start` and later reads the two divisors when `done` pulses. The generator stretches each phase to `8 * (divisor + 1)` functional clocks.

The unit enforces three limits together. The SCL frequency never exceeds the request. The low phase never falls below its minimum, and neither does the high phase. When the two phase minimums already need more counts than the frequency target allows, the minimums win and the bus runs slower. When they need fewer, the leftover counts are shared out so that the low phase gets its proportional share, rounded up. This biases the split toward a longer low phase.

All quotients come from one iterative divider that retires one quotient bit per cycle and always rounds up. A request takes four such divisions and then one cycle to split the counts.

Top module: `scl_div_calc`

## Requirements
- R1: At every `done`, `(div_low+1)+(div_high+1)` is at least ceil(clk_rate / (8*scl_rate)), so SCL never runs faster than requested.
- R2: At every `done`, `div_low+1` is at least ceil(clk_rate*low_ns / 8e9).
- R3: At every `done`, `div_high+1` is at least ceil(clk_rate*high_ns / 8e9).
- R4: When the low and high minimum counts from R2 and R3 together exceed the total from R1, the output counts are exactly those two minimums.
- R5: In any other case the low count is ceil(clk_rate*low_ns / (8*scl_rate*(low_ns+high_ns))). This value is limited to the total minus the high minimum, and is never below the low minimum. The high count is the total minus the low count.
- R6: Each output equals its count minus one, because the generator adds one internally.
- R7: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse, and `busy` is low while it is high.
- R8: A `start` that arrives while `busy` is high has no effect. The result reported at the next `done` belongs to the request that was accepted.
- R9: `div_low` and `div_high` change only in the cycle where `done` is high, and they hold between completions.
- R10: A `start` from idle with any of `clk_rate`, `scl_rate`, `low_ns` or `high_ns` equal to zero sets `err`. It does not raise `busy` or `done` and leaves the outputs unchanged. The next accepted `start` clears `err`.
- R11: Every internal quotient is rounded up. For example, a low or high minimum of 0.96 counts becomes 1, so the matching output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| clk_rate | input | 32 | Functional clock rate in Hz |
| scl_rate | input | 32 | Requested SCL rate in Hz |
| low_ns | input | 16 | Minimum SCL low time in ns |
| high_ns | input | 16 | Minimum SCL high time in ns |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse, divisors valid |
| err | output | 1 | Last request had a zero operand |
| div_low | output | 32 | Low-phase divisor, count minus one |
| div_high | output | 32 | High-phase divisor, count minus one |

## Verification
A wrong quotient or rounding in the divider shows up in the first `done` after the faulty division. It appears as an output off by one or more from the independently computed pair, or as a sum below the frequency floor. A stale operand, a start accepted while busy, or a broken step counter shows up as a result belonging to the wrong request, or as `done` arriving late or never. The watchdog catches the last case. A broken split or clamp shows up only in requests that hit the clamp or the minimum-wins path, so the directed cases cover each of those paths.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  parameter int unsigned QW = 64;

  // 8 * 1e9: eight clocks per count, nanoseconds per second
  localparam logic [QW-1:0] NS_COUNT_DEN = QW'(64'd8000000000);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_SPLIT
  } calc_state_e;

  typedef enum logic [1:0] {
    OP_TOTAL  = 2'd0,
    OP_MIN_LO = 2'd1,
    OP_MIN_HI = 2'd2,
    OP_IDEAL  = 2'd3
  } calc_op_e;

  typedef struct packed {
    logic [QW-1:0] lo;
    logic [QW-1:0] hi;
    logic          hold_wins;
  } split_t;

  // Distribute counts between the two phases (counts, before the minus one)
  function automatic split_t split_counts(input logic [QW-1:0] total,
                                          input logic [QW-1:0] min_lo,
                                          input logic [QW-1:0] min_hi,
                                          input logic [QW-1:0] ideal);
    split_t r;
    logic [QW-1:0] floor_sum;
    logic [QW-1:0] spare;
    logic [QW-1:0] cap;
    logic [QW-1:0] lo;
    floor_sum = min_lo + min_hi;
    r.hold_wins = 1'b0;
    if (floor_sum > total) begin
      r.hold_wins = 1'b1;
      r.lo = min_lo;
      r.hi = min_hi;
    end else begin
      spare = total - floor_sum;
      cap   = min_lo + spare;
      lo    = (ideal > cap) ? cap : ideal;
      if (lo < min_lo) lo = min_lo;
      r.lo = lo;
      r.hi = min_hi + (cap - lo);
    end
    return r;
  endfunction

endpackage

// File: rtl/scl_ceil_div.sv
module scl_ceil_div #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] numer,
  input  logic [W-1:0] denom,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  acc_q;
  logic [W-1:0]  den_q;
  logic [W-1:0]  num_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fin_q;

  logic [W:0]    trial_w;
  logic          fit_w;

  assign trial_w = {rem_q[W-1:0], acc_q[W-1]};
  assign fit_w   = trial_w >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      den_q <= '0;
      num_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        // rounding up: divide (n + d - 1) by d
        acc_q <= numer + denom - W'(1);
        rem_q <= '0;
        den_q <= denom;
        num_q <= numer;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fit_w) begin
          rem_q <= trial_w - {1'b0, den_q};
          acc_q <= {acc_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial_w;
          acc_q <= {acc_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign busy = run_q;
  assign fin  = fin_q;
  assign quot = acc_q;

  // Checks local to the divider
  logic [W:0]     padded_w;
  logic [2*W-1:0] prod_w;
  logic [2*W-1:0] prod_less_w;
  logic [2*W-1:0] num_ext_w;

  assign padded_w    = {1'b0, numer} + {1'b0, denom} - (W+1)'(1);
  assign prod_w      = {{W{1'b0}}, acc_q} * {{W{1'b0}}, den_q};
  assign prod_less_w = prod_w - {{W{1'b0}}, den_q};
  assign num_ext_w   = {{W{1'b0}}, num_q};

  a_r11_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> denom != '0);

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !padded_w[W]);

  a_r11_ceil: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (prod_w >= num_ext_w) && ((acc_q == '0) || (prod_less_w < num_ext_w)));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !go);

endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc
  import scl_div_pkg::*;
#(
  parameter int unsigned RATE_W = 32,
  parameter int unsigned NS_W   = 16,
  parameter int unsigned DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] clk_rate,
  input  logic [RATE_W-1:0] scl_rate,
  input  logic [NS_W-1:0]   low_ns,
  input  logic [NS_W-1:0]   high_ns,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DIV_W-1:0]  div_low,
  output logic [DIV_W-1:0]  div_high
);
  localparam int unsigned NOPS = 4;

  calc_state_e state_q;
  calc_op_e    op_q;

  logic [RATE_W-1:0] clk_q;
  logic [RATE_W-1:0] scl_q;
  logic [NS_W-1:0]   lo_ns_q;
  logic [NS_W-1:0]   hi_ns_q;
  logic [QW-1:0]     res_q [NOPS];
  logic              done_q;
  logic              err_q;
  logic [DIV_W-1:0]  div_lo_q;
  logic [DIV_W-1:0]  div_hi_q;

  // Named internal events
  logic          idle_w;
  logic          zero_w;
  logic          accept_w;
  logic          reject_w;
  logic          div_go_w;
  logic          div_busy_w;
  logic          div_fin_w;
  logic [QW-1:0] div_quot_w;
  logic [QW-1:0] numer_w;
  logic [QW-1:0] denom_w;
  split_t        split_w;

  assign idle_w   = (state_q == ST_IDLE);
  assign zero_w   = (clk_rate == '0) || (scl_rate == '0) ||
                    (low_ns == '0) || (high_ns == '0);
  assign accept_w = start && idle_w && !zero_w;
  assign reject_w = start && idle_w && zero_w;
  assign div_go_w = (state_q == ST_LAUNCH);

  // Operand selection for each of the four divisions
  always_comb begin
    numer_w = QW'(clk_q) * QW'(lo_ns_q);
    denom_w = NS_COUNT_DEN;
    unique case (op_q)
      OP_TOTAL: begin
        numer_w = QW'(clk_q);
        denom_w = QW'(scl_q) << 3;
      end
      OP_MIN_LO: begin
        numer_w = QW'(clk_q) * QW'(lo_ns_q);
        denom_w = NS_COUNT_DEN;
      end
      OP_MIN_HI: begin
        numer_w = QW'(clk_q) * QW'(hi_ns_q);
        denom_w = NS_COUNT_DEN;
      end
      OP_IDEAL: begin
        numer_w = QW'(clk_q) * QW'(lo_ns_q);
        denom_w = (QW'(scl_q) << 3) * (QW'(lo_ns_q) + QW'(hi_ns_q));
      end
      default: ;
    endcase
  end

  scl_ceil_div #(.W(QW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go_w),
    .numer (numer_w),
    .denom (denom_w),
    .busy  (div_busy_w),
    .fin   (div_fin_w),
    .quot  (div_quot_w)
  );

  assign split_w = split_counts(res_q[OP_TOTAL], res_q[OP_MIN_LO],
                                res_q[OP_MIN_HI], res_q[OP_IDEAL]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_TOTAL;
      clk_q    <= '0;
      scl_q    <= '0;
      lo_ns_q  <= '0;
      hi_ns_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      div_lo_q <= '0;
      div_hi_q <= '0;
      for (int i = 0; i < NOPS; i++) res_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            clk_q   <= clk_rate;
            scl_q   <= scl_rate;
            lo_ns_q <= low_ns;
            hi_ns_q <= high_ns;
            op_q    <= OP_TOTAL;
            err_q   <= 1'b0;
            state_q <= ST_LAUNCH;
          end else if (reject_w) begin
            err_q <= 1'b1;
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_fin_w) begin
            res_q[op_q] <= div_quot_w;
            if (op_q == OP_IDEAL) begin
              state_q <= ST_SPLIT;
            end else begin
              op_q    <= calc_op_e'(op_q + 2'd1);
              state_q <= ST_LAUNCH;
            end
          end
        end
        ST_SPLIT: begin
          div_lo_q <= DIV_W'(split_w.lo - QW'(1));
          div_hi_q <= DIV_W'(split_w.hi - QW'(1));
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = !idle_w;
  assign done     = done_q;
  assign err      = err_q;
  assign div_low  = div_lo_q;
  assign div_high = div_hi_q;

  // Assertions next to the logic they guard
  logic [QW-1:0] lo_cnt_w;
  logic [QW-1:0] hi_cnt_w;
  assign lo_cnt_w = QW'(div_lo_q) + QW'(1);
  assign hi_cnt_w = QW'(div_hi_q) + QW'(1);

  a_r1_rate_floor: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lo_cnt_w + hi_cnt_w) >= res_q[OP_TOTAL]);

  a_r2_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lo_cnt_w >= res_q[OP_MIN_LO]);

  a_r3_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hi_cnt_w >= res_q[OP_MIN_HI]);

  a_r4_hold_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res_q[OP_MIN_LO] + res_q[OP_MIN_HI] > res_q[OP_TOTAL]))
      |-> (lo_cnt_w == res_q[OP_MIN_LO]) && (hi_cnt_w == res_q[OP_MIN_HI]));

  a_r5_exact_total: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res_q[OP_MIN_LO] + res_q[OP_MIN_HI] <= res_q[OP_TOTAL]))
      |-> (lo_cnt_w + hi_cnt_w) == res_q[OP_TOTAL]);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_div_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy_w |-> busy);

  a_r8_operands_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(clk_q) && $stable(scl_q) &&
                               $stable(lo_ns_q) && $stable(hi_ns_q)));

  a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(div_low) && $stable(div_high)));

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> (err && !busy && !done));

endmodule

// File: tb/scl_div_calc_tb.sv
module scl_div_calc_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] clk_rate = '0;
  logic [31:0] scl_rate = '0;
  logic [15:0] low_ns = '0;
  logic [15:0] high_ns = '0;
  logic        busy, done, err;
  logic [31:0] div_low, div_high;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_div_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .clk_rate(clk_rate), .scl_rate(scl_rate),
    .low_ns(low_ns), .high_ns(high_ns),
    .busy(busy), .done(done), .err(err),
    .div_low(div_low), .div_high(div_high)
  );

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned up_div(input longint unsigned a,
                                             input longint unsigned b);
    longint unsigned q;
    q = a / b;
    if (q * b != a) q++;
    return q;
  endfunction

  // Independent restatement of the requirements (counts, not outputs)
  task automatic ref_counts(input longint unsigned c, input longint unsigned s,
                            input longint unsigned l, input longint unsigned h,
                            output longint unsigned tot, output longint unsigned ml,
                            output longint unsigned mh, output longint unsigned lo,
                            output longint unsigned hi);
    longint unsigned want_lo;
    tot = up_div(c, 8 * s);
    ml  = up_div(c * l, 64'd8000000000);
    mh  = up_div(c * h, 64'd8000000000);
    if (ml + mh > tot) begin
      lo = ml;
      hi = mh;
    end else begin
      want_lo = up_div(c * l, 8 * s * (l + h));
      lo = (want_lo < tot - mh) ? want_lo : tot - mh;
      if (lo < ml) lo = ml;
      hi = tot - lo;
    end
  endtask

  task automatic pulse_start(input longint unsigned c, input longint unsigned s,
                             input longint unsigned l, input longint unsigned h);
    @(negedge clk);
    clk_rate = 32'(c);
    scl_rate = 32'(s);
    low_ns   = 16'(l);
    high_ns  = 16'(h);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_result(input string tag, input longint unsigned c,
                              input longint unsigned s, input longint unsigned l,
                              input longint unsigned h);
    longint unsigned tot, ml, mh, lo, hi;
    ref_counts(c, s, l, h, tot, ml, mh, lo, hi);
    chk("R5", {tag, " div_low"}, div_low, lo - 1);
    chk("R6", {tag, " div_high"}, div_high, hi - 1);
    chk("R1", {tag, " rate floor met"},
        ((64'(div_low) + 64'(div_high) + 2) >= tot) ? 1 : 0, 1);
    chk("R2", {tag, " low minimum met"}, (64'(div_low) + 1 >= ml) ? 1 : 0, 1);
    chk("R3", {tag, " high minimum met"}, (64'(div_high) + 1 >= mh) ? 1 : 0, 1);
    if (ml + mh > tot) begin
      chk("R4", {tag, " low equals minimum"}, 64'(div_low) + 1, ml);
      chk("R4", {tag, " high equals minimum"}, 64'(div_high) + 1, mh);
    end
    chk("R7", {tag, " busy low at done"}, busy, 0);
    @(negedge clk);
    chk("R7", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic run_case(input string tag, input longint unsigned c,
                          input longint unsigned s, input longint unsigned l,
                          input longint unsigned h);
    pulse_start(c, s, l, h);
    chk("R7", {tag, " busy after start"}, busy, 1);
    chk("R10", {tag, " err clear on accept"}, err, 0);
    wait_done();
    check_result(tag, c, s, l, h);
  endtask

  task automatic test_reset();
    chk("R7", "reset busy", busy, 0);
    chk("R7", "reset done", done, 0);
    chk("R10", "reset err", err, 0);
    chk("R9", "reset div_low", div_low, 0);
    chk("R9", "reset div_high", div_high, 0);
  endtask

  // R11: 0.96 count rounds to 1, so the high output is 0
  task automatic test_rounding();
    run_case("round", 12800000, 400000, 1300, 600);
    chk("R11", "high count rounded up", div_high, 0);
    chk("R11", "low count rounded up", div_low, 2);
  endtask

  // R4: minimums exceed the frequency floor
  task automatic test_hold_wins();
    run_case("holdwin", 800000, 400000, 1300, 600);
  endtask

  // R5: ideal low exceeds what is left, clamp applies
  task automatic test_clamp();
    run_case("clamp", 1484000, 100000, 4700, 4000);
  endtask

  task automatic test_spare();
    run_case("std", 74250000, 100000, 4700, 4000);
    run_case("fast", 74250000, 400000, 1300, 600);
    run_case("odd", 74250000, 99797, 4700, 4000);
  endtask

  // R8: second start during a run must not change anything
  task automatic test_start_busy();
    pulse_start(50000000, 100000, 4700, 4000);
    repeat (20) @(negedge clk);
    start    = 1'b1;
    clk_rate = 32'd9400000;
    scl_rate = 32'd400000;
    low_ns   = 16'd1300;
    high_ns  = 16'd600;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "busy stays high", busy, 1);
    wait_done();
    check_result("busystart R8", 50000000, 100000, 4700, 4000);
    chk("R8", "no second run", busy, 0);
  endtask

  // R9: outputs hold between completions
  task automatic test_hold_outputs();
    logic [31:0] lo0, hi0;
    lo0 = div_low;
    hi0 = div_high;
    repeat (30) @(negedge clk);
    chk("R9", "div_low held", div_low, lo0);
    chk("R9", "div_high held", div_high, hi0);
  endtask

  // R10: zero operand rejected
  task automatic test_zero();
    logic [31:0] lo0, hi0;
    int seen;
    lo0 = div_low;
    hi0 = div_high;
    pulse_start(74250000, 0, 4700, 4000);
    chk("R10", "err set on zero scl", err, 1);
    chk("R10", "not busy on zero scl", busy, 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (done) seen++;
      @(negedge clk);
    end
    chk("R10", "no done on zero scl", seen, 0);
    chk("R10", "div_low unchanged", div_low, lo0);
    chk("R10", "div_high unchanged", div_high, hi0);
    pulse_start(74250000, 400000, 0, 600);
    chk("R10", "err set on zero low_ns", err, 1);
    chk("R10", "not busy on zero low_ns", busy, 0);
    run_case("after err R10", 6400000, 400000, 1300, 600);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_rounding();
    test_hold_wins();
    test_clamp();
    test_spare();
    test_hold_outputs();
    test_start_busy();
    test_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule